// File: doc/BRIEF.md
# ADC Result Window Monitor

This block watches the conversion results of a multi-sequencer ADC interface and raises a flag when a result falls into a programmed region. One monitor unit exists per sequencer. Each unit follows the writes into its sequencer's result slots and evaluates only the slot chosen by its source index. On that write it compares the result with a low and a high threshold under one of five mode codes. A hit sets a sticky flag, and the flag can be routed to an interrupt line.

Results and thresholds are signed two's-complement numbers. The flag holds its value until software acknowledges it by pulsing the unit's clear input. When an acknowledge and a new hit arrive in the same cycle, the hit is kept, so no event is lost. Threshold calibration and register decoding are done outside the block.

Top module: `adc_window_watch`

## Requirements
- R1: After a synchronous active-low reset, every flag and every interrupt output is 0.
- R2: Mode code 0 (off, the reset default) and the unused codes 5, 6 and 7 never set the flag.
- R3: Mode code 1 sets the flag when the result is strictly less than the high threshold. A result equal to the high threshold does not set it.
- R4: Mode code 2 sets the flag when the result is strictly greater than the low threshold. A result equal to the low threshold does not set it.
- R5: Mode code 3 sets the flag when low < result < high. A result equal to either threshold does not set it.
- R6: Mode code 4 sets the flag when the result is below the low threshold or above the high threshold. A result equal to either threshold does not set it.
- R7: All comparisons treat the result and the thresholds as signed two's-complement values of RES_W bits. With RES_W=12, the value 0x800 is -2048.
- R8: A unit evaluates a result only in a cycle where its write strobe is high and the written slot index equals its source index. Writes to other slots, and cycles without a strobe, leave the flag unchanged.
- R9: A set flag stays at 1 until a cycle with clear high. It reads 0 from the cycle after that clear, provided that cycle has no hit.
- R10: If clear and a hit occur in the same cycle, the flag is 1 after that cycle.
- R11: Each interrupt output equals its unit's flag ANDed with its interrupt enable. The output follows the enable without delay.
- R12: The units are independent. A hit or a clear on one unit does not change another unit's flag.
- R13: A flag becomes visible on the clock edge that samples the qualifying write, one cycle after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | NUM_MON | Result write strobe, one bit per sequencer |
| wr_slot | input | NUM_MON*SLOT_W | Index of the slot being written, per sequencer |
| wr_data | input | NUM_MON*RES_W | Signed result being written, per sequencer |
| mode | input | NUM_MON*3 | Comparison mode code, per unit |
| src_slot | input | NUM_MON*SLOT_W | Slot index each unit watches |
| thr_lo | input | NUM_MON*RES_W | Signed low threshold, per unit |
| thr_hi | input | NUM_MON*RES_W | Signed high threshold, per unit |
| clr | input | NUM_MON | Write-one acknowledge pulse, per unit |
| irq_en | input | NUM_MON | Interrupt enable, per unit |
| flag | output | NUM_MON | Sticky hit status, per unit |
| irq | output | NUM_MON | Interrupt request, per unit |

## Verification
The bench builds the block with its defaults: NUM_MON=2, RES_W=12 and SLOT_W=3. Two units are enough to show that one unit's hit or clear does not reach the other. Twelve-bit results put the sign boundary at 0x800, which an unsigned comparison would handle wrongly. Eight slots leave room to write to slots that differ from the watched one. Each mode is driven with results exactly at the thresholds, one step inside them and one step outside them.

// File: rtl/wwm_pkg.sv
// Shared types for the window monitor: the mode code enumeration.
// Assumes 3-bit mode codes. Codes outside the enumeration mean "off".
package wwm_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        WM_OFF      = 3'd0,
        WM_BELOW_HI = 3'd1,
        WM_ABOVE_LO = 3'd2,
        WM_INSIDE   = 3'd3,
        WM_OUTSIDE  = 3'd4
    } wm_mode_e;
endpackage

// File: rtl/wwm_compare.sv
// Combinational window test of one signed result against two signed
// thresholds, chosen by mode code. Assumes lo <= hi is the caller's concern.
module wwm_compare
    import wwm_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0]  res,
    input  logic [RES_W-1:0]  lo,
    input  logic [RES_W-1:0]  hi,
    input  logic [MODE_W-1:0] mode,
    output logic              hit
);
    logic signed [RES_W-1:0] s_res, s_lo, s_hi;
    logic below_hi, above_lo, below_lo, above_hi;

    // signed views and the four strict relations
    always_comb begin
        s_res    = $signed(res);
        s_lo     = $signed(lo);
        s_hi     = $signed(hi);
        below_hi = s_res < s_hi;
        above_lo = s_res > s_lo;
        below_lo = s_res < s_lo;
        above_hi = s_res > s_hi;
    end

    // select the relation named by the mode code
    always_comb begin
        case (mode)
            WM_BELOW_HI: hit = below_hi;
            WM_ABOVE_LO: hit = above_lo;
            WM_INSIDE:   hit = above_lo && below_hi;
            WM_OUTSIDE:  hit = below_lo || above_hi;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/wwm_unit.sv
// One monitor: slot filter, window test, sticky flag with write-one clear
// and interrupt gating. Assumes inputs are synchronous to clk.
module wwm_unit
    import wwm_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [RES_W-1:0]  wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic [SLOT_W-1:0] src_slot,
    input  logic [RES_W-1:0]  thr_lo,
    input  logic [RES_W-1:0]  thr_hi,
    input  logic              clr,
    input  logic              irq_en,
    output logic              flag,
    output logic              irq
);
    logic sel;
    logic hit;

    // watched-slot write detection
    always_comb sel = wr_valid && (wr_slot == src_slot);

    wwm_compare #(.RES_W(RES_W)) i_cmp (
        .res (wr_data),
        .lo  (thr_lo),
        .hi  (thr_hi),
        .mode(mode),
        .hit (hit)
    );

    // sticky flag: a hit wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          flag <= 1'b0;
        else if (sel && hit) flag <= 1'b1;
        else if (clr)        flag <= 1'b0;
    end

    // interrupt gating
    always_comb irq = flag && irq_en;

    // R1: reset clears the flag
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !flag);

    // R2: off and unused codes never set the flag
    p_off_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && (mode == 3'd0 || mode > 3'd4)) |=> !flag);

    // R8: flag cannot rise without a write to the watched slot
    p_slot_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !sel) |=> !flag);

    // R9: flag holds without an acknowledge
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R9: acknowledge without hit clears
    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(sel && hit)) |=> !flag);

    // R10: hit beats acknowledge
    p_hit_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && sel && hit) |=> flag);

    // R11: a disabled interrupt stays low
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: rtl/adc_window_watch.sv
// Top: one window monitor per sequencer, ports flattened per unit.
// Assumes unit m uses bit slice m of each packed vector.
module adc_window_watch #(
    parameter int NUM_MON = 2,
    parameter int RES_W   = 12,
    parameter int SLOT_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MON-1:0]        wr_valid,
    input  logic [NUM_MON*SLOT_W-1:0] wr_slot,
    input  logic [NUM_MON*RES_W-1:0]  wr_data,
    input  logic [NUM_MON*3-1:0]      mode,
    input  logic [NUM_MON*SLOT_W-1:0] src_slot,
    input  logic [NUM_MON*RES_W-1:0]  thr_lo,
    input  logic [NUM_MON*RES_W-1:0]  thr_hi,
    input  logic [NUM_MON-1:0]        clr,
    input  logic [NUM_MON-1:0]        irq_en,
    output logic [NUM_MON-1:0]        flag,
    output logic [NUM_MON-1:0]        irq
);
    localparam int MW = wwm_pkg::MODE_W;

    for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
        wwm_unit #(.RES_W(RES_W), .SLOT_W(SLOT_W)) i_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_valid(wr_valid[m]),
            .wr_slot (wr_slot[m*SLOT_W +: SLOT_W]),
            .wr_data (wr_data[m*RES_W +: RES_W]),
            .mode    (mode[m*MW +: MW]),
            .src_slot(src_slot[m*SLOT_W +: SLOT_W]),
            .thr_lo  (thr_lo[m*RES_W +: RES_W]),
            .thr_hi  (thr_hi[m*RES_W +: RES_W]),
            .clr     (clr[m]),
            .irq_en  (irq_en[m]),
            .flag    (flag[m]),
            .irq     (irq[m])
        );
    end
endmodule

// File: tb/test_adc_window_watch.sv
module test_adc_window_watch;
    localparam int NM = 2;
    localparam int RW = 12;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0] wv = '0, c = '0, en = '0;
    logic [SW-1:0] b_slot [NM];
    logic [SW-1:0] b_src  [NM];
    logic [RW-1:0] b_data [NM];
    logic [RW-1:0] b_lo   [NM];
    logic [RW-1:0] b_hi   [NM];
    logic [2:0]    b_mode [NM];
    logic [NM-1:0] flag, irq;
    logic [NM-1:0] mflag = '0;

    int checks = 0;
    int errors = 0;
    logic [2*NM-1:0] exp_q [$];
    string           tag_q [$];

    always #10 clk = ~clk;

    adc_window_watch #(.NUM_MON(NM), .RES_W(RW), .SLOT_W(SW)) i_adc_window_watch (
        .clk(clk), .rst_n(rst_n), .wr_valid(wv),
        .wr_slot({b_slot[1], b_slot[0]}), .wr_data({b_data[1], b_data[0]}),
        .mode({b_mode[1], b_mode[0]}), .src_slot({b_src[1], b_src[0]}),
        .thr_lo({b_lo[1], b_lo[0]}), .thr_hi({b_hi[1], b_hi[0]}),
        .clr(c), .irq_en(en), .flag(flag), .irq(irq));

    // reference rule taken from the requirements
    function automatic bit model_hit(logic [2:0] md, logic [RW-1:0] d,
                                     logic [RW-1:0] lo, logic [RW-1:0] hi);
        int sd = $signed(d), sl = $signed(lo), sh = $signed(hi);
        case (md)
            3'd1: return sd < sh;
            3'd2: return sd > sl;
            3'd3: return (sd > sl) && (sd < sh);
            3'd4: return (sd < sl) || (sd > sh);
            default: return 1'b0;
        endcase
    endfunction

    // driver: predict the state after the coming edge, queue it, clock it
    task automatic tick(string tag);
        for (int m = 0; m < NM; m++) begin
            if (wv[m] && b_slot[m] == b_src[m] &&
                model_hit(b_mode[m], b_data[m], b_lo[m], b_hi[m])) mflag[m] = 1'b1;
            else if (c[m]) mflag[m] = 1'b0;
        end
        exp_q.push_back({mflag & en, mflag});
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        wv = '0;
        c  = '0;
    endtask

    task automatic wr(int m, int slot, int data, string tag);
        wv[m] = 1'b1;
        b_slot[m] = SW'(slot);
        b_data[m] = RW'(data);
        tick(tag);
    endtask

    task automatic ack(int m, string tag);
        c[m] = 1'b1;
        tick(tag);
    endtask

    task automatic cfg(int m, int md, int src, int lo, int hi);
        b_mode[m] = 3'(md);
        b_src[m]  = SW'(src);
        b_lo[m]   = RW'(lo);
        b_hi[m]   = RW'(hi);
    endtask

    // monitor: pop and compare shortly after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [2*NM-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({irq, flag} !== e) begin
                errors++;
                $display("FAIL %s flag=%b irq=%b expected flag=%b irq=%b",
                         t, flag, irq, e[NM-1:0], e[2*NM-1:NM]);
            end
        end
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int m = 0; m < NM; m++) begin
            cfg(m, 0, 0, 0, 0);
            b_slot[m] = '0;
            b_data[m] = '0;
        end
        en = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (flag !== '0 || irq !== '0) begin
            errors++;
            $display("FAIL R1 flag=%b irq=%b expected flag=00 irq=00", flag, irq);
        end
        rst_n = 1'b1;
        @(negedge clk);

        cfg(0, 0, 0, -100, 200);  wr(0, 0, 0,   "R2 mode 0");
        cfg(0, 5, 0, -100, 200);  wr(0, 0, 0,   "R2 code 5");
        cfg(0, 7, 0, -100, 200);  wr(0, 0, 500, "R2 code 7");

        cfg(0, 1, 0, -100, 200);  wr(0, 0, 200, "R3 equal hi");
        wr(0, 0, 199, "R3 below hi");          ack(0, "R9 ack");
        cfg(0, 2, 0, -100, 200);  wr(0, 0, -100, "R4 equal lo");
        wr(0, 0, -99, "R4 above lo");          ack(0, "R9 ack");
        cfg(0, 3, 0, -100, 200);  wr(0, 0, 200, "R5 at hi");
        wr(0, 0, -100, "R5 at lo");
        wr(0, 0, 0, "R5 inside");              ack(0, "R9 ack");
        cfg(0, 4, 0, -100, 200);  wr(0, 0, 200, "R6 at hi");
        wr(0, 0, -100, "R6 at lo");
        wr(0, 0, 201, "R6 above hi");          ack(0, "R9 ack");
        wr(0, 0, -101, "R6 below lo");         ack(0, "R9 ack");

        cfg(0, 1, 0, -100, 200);  wr(0, 0, 'h800, "R7 0x800 is negative");
        ack(0, "R9 ack");
        cfg(0, 2, 0, 'h7F0, 0);   wr(0, 0, 'h810, "R7 negative not above");

        cfg(0, 1, 2, -100, 200);  wr(0, 3, 0, "R8 other slot");
        tick("R8 no strobe");
        wr(0, 2, 0, "R8 watched slot / R13");
        wr(0, 2, 900, "R9 non-hit keeps flag");
        tick("R9 idle keeps flag");
        ack(0, "R9 ack clears");

        c[0] = 1'b1;              wr(0, 2, 0, "R10 hit beats clear");
        en[0] = 1'b0;             tick("R11 irq masked");
        en[0] = 1'b1;             tick("R11 irq follows enable");
        ack(0, "R9 ack");

        cfg(1, 4, 5, -10, 10);    wr(1, 5, 50, "R12 unit 1 hit");
        tick("R12 unit 0 untouched");
        wr(0, 2, 0, "R12 unit 0 hit");
        ack(1, "R12 clear unit 1 only");
        ack(0, "R12 clear unit 0");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule